// File: doc/BRIEF.md
# Random Word Output Buffer with Event Status

This block is the register front end of a hardware random number generator. It takes conditioned 32-bit words from an upstream source. It collects four of them into an output buffer and raises a ready flag once the set is complete and a programmable minimum number of cycles has passed since the refill began. If a programmable maximum is reached first, the refill is declared complete with whatever words have arrived.

Software reads the buffered words through a simple register port. It acknowledges them by writing one to the ready bit, and that write also starts the next refill. The block compares each accepted word with the previous one and flags a repeat as a stuck output. It also latches event pulses from the oscillator controller and the health tester. All of these flags sit in one write-one-to-clear status register, and each flag has its own interrupt enable. The register port has a single-cycle write strobe. Reads are combinational from the address.

Top module: `rng_obuf_top`

## Requirements
- R1: While ready is high, reads at offsets 0x00, 0x04, 0x08 and 0x0C return the accepted words of the current set, in the order they arrived.
- R2: While ready is low, reads at the four data offsets return zero. Writes to the data offsets change nothing.
- R3: Ready is status bit 0 at offset 0x10. It sets once four words have been accepted and the cycle count since the refill began has reached the minimum held in bits 7:0 of the configuration register at offset 0x18.
- R4: When bits 31:16 of the configuration register are nonzero and the refill cycle count reaches that value, ready sets even if fewer than four words have arrived. Words that never arrived read as zero.
- R5: Writing 1 to status bit 0 while ready is high clears ready and starts a new refill. No input word is accepted while ready is high.
- R6: If two consecutively accepted input words are equal, status bit 2 sets.
- R7: A pulse on the oscillator-shutdown input sets status bit 1. A pulse on health-fail input k (k = 0..4) sets status bit 3+k. These bits stay set until they are cleared.
- R8: Writing 1 to any of status bits 1..7 clears that bit. Writing 0 leaves it unchanged. An event in the same cycle as its clear keeps the bit set.
- R9: Bit 10 of the control register at offset 0x14 enables the generator. While it is 0, no words are accepted and ready does not rise.
- R10: The irq output is high when any of status bits 1..7 is set and the matching bit of control bits 7:1 is also set. Ready never causes an interrupt.
- R11: The control register reads back only bits 10 and 7:1, with all other bits zero. The configuration register reads back only bits 31:16 and 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| rnd_valid | input | 1 | Input word valid |
| rnd_data | input | 32 | Conditioned random input word |
| fro_shutdown | input | 1 | Oscillator shutdown event pulse |
| health_fail | input | 5 | Health-test failure event pulses |
| irq | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle and check the following:
- Data reads return zero whenever ready is low.
- An acknowledge of ready drops it on the next cycle.
- Ready only rises after a cycle in which the generator was enabled.
- A detected repeat always lands in the stuck bit.
- Interrupts stay silent while every enable is clear.

Only the bench scenarios can show the rest:
- The minimum and maximum refill timing.
- The order and content of the buffered words.
- The zero fill after a forced completion.
- The set-over-clear priority.
- The register readback masks.

// File: rtl/rng_obuf_pkg.sv
package rng_obuf_pkg;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_WORDS = 4;
    localparam int unsigned MIN_W     = 8;
    localparam int unsigned MAX_W     = 16;
    localparam int unsigned EVT_HI    = 7;
    localparam int unsigned EN_BIT    = 10;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h18;

    typedef struct packed {
        logic              enable;
        logic [EVT_HI:1]   ien;
        logic [MAX_W-1:0]  max_cyc;
        logic [MIN_W-1:0]  min_cyc;
    } cfg_regs_t;
endpackage

// File: rtl/rng_fill.sv
module rng_fill #(
    parameter int unsigned WORDS = 4,
    parameter int unsigned DW    = 32,
    parameter int unsigned MINW  = 8,
    parameter int unsigned MAXW  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      in_valid,
    input  logic [DW-1:0]             in_data,
    input  logic [MINW-1:0]           min_cyc,
    input  logic [MAXW-1:0]           max_cyc,
    input  logic                      restart,
    output logic                      accept,
    output logic                      ready,
    output logic [WORDS-1:0][DW-1:0]  words
);
    localparam int unsigned IDX_W = $clog2(WORDS + 1);

    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] words;
        logic [IDX_W-1:0]         idx;
        logic [MAXW-1:0]          cyc;
        logic                     ready;
    } fill_t;

    fill_t st_d, st_q;
    logic  filling;

    always_comb begin
        st_d    = st_q;
        filling = en && !st_q.ready;
        accept  = filling && in_valid && (st_q.idx < IDX_W'(WORDS));
        if (restart && st_q.ready) begin
            st_d.ready = 1'b0;
            st_d.idx   = '0;
            st_d.cyc   = '0;
            st_d.words = '0;
        end else if (filling) begin
            if (accept) begin
                for (int i = 0; i < WORDS; i++)
                    if (st_q.idx == IDX_W'(i)) st_d.words[i] = in_data;
                st_d.idx = st_q.idx + 1'b1;
            end
            if (st_q.cyc != '1) st_d.cyc = st_q.cyc + 1'b1;
            if ((st_q.idx == IDX_W'(WORDS) && st_q.cyc >= MAXW'(min_cyc)) ||
                (max_cyc != '0 && st_q.cyc >= max_cyc))
                st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.ready;
    assign words = st_q.words;
endmodule

// File: rtl/rng_stuck.sv
module rng_stuck #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [DW-1:0] in_data,
    output logic          stuck_evt
);
    typedef struct packed {
        logic [DW-1:0] last;
        logic          have;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        stuck_evt = accept && c_q.have && (in_data == c_q.last);
        if (accept) begin
            c_d.last = in_data;
            c_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/rng_status.sv
module rng_status #(
    parameter int unsigned HI = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [HI:1] set_evt,
    input  logic [HI:1] clr_mask,
    input  logic [HI:1] ien,
    output logic [HI:1] sts,
    output logic        irq
);
    logic [HI:1] sts_d, sts_q;

    always_comb begin
        sts_d = (sts_q & ~clr_mask) | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts = sts_q;
    assign irq = |(sts_q & ien);
endmodule

// File: rtl/rng_obuf_top.sv
module rng_obuf_top
    import rng_obuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rnd_valid,
    input  logic [DATA_W-1:0] rnd_data,
    input  logic              fro_shutdown,
    input  logic [4:0]        health_fail,
    output logic              irq
);
    cfg_regs_t regs_d, regs_q;
    logic                            wr_sts;
    logic                            accept;
    logic                            ready;
    logic                            stuck_evt;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    logic [EVT_HI:1]                 sts;
    logic [EVT_HI:1]                 set_evt;

    assign wr_sts  = reg_wr && (reg_addr == OFS_STATUS);
    assign set_evt = {health_fail, stuck_evt, fro_shutdown};

    always_comb begin
        regs_d = regs_q;
        if (reg_wr && reg_addr == OFS_CTRL) begin
            regs_d.enable = reg_wdata[EN_BIT];
            regs_d.ien    = reg_wdata[EVT_HI:1];
        end
        if (reg_wr && reg_addr == OFS_CFG) begin
            regs_d.max_cyc = reg_wdata[DATA_W-1 -: MAX_W];
            regs_d.min_cyc = reg_wdata[MIN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    rng_fill #(.WORDS(NUM_WORDS), .DW(DATA_W), .MINW(MIN_W), .MAXW(MAX_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .en(regs_q.enable),
        .in_valid(rnd_valid), .in_data(rnd_data),
        .min_cyc(regs_q.min_cyc), .max_cyc(regs_q.max_cyc),
        .restart(wr_sts && reg_wdata[0]),
        .accept(accept), .ready(ready), .words(words)
    );

    rng_stuck #(.DW(DATA_W)) u_stuck (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .in_data(rnd_data), .stuck_evt(stuck_evt)
    );

    rng_status #(.HI(EVT_HI)) u_status (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
        .clr_mask(wr_sts ? reg_wdata[EVT_HI:1] : '0),
        .ien(regs_q.ien), .sts(sts), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (reg_addr == ADDR_W'(4 * i) && ready) reg_rdata = words[i];
        case (reg_addr)
            OFS_STATUS: reg_rdata[EVT_HI:0] = {sts, ready};
            OFS_CTRL: begin
                reg_rdata[EN_BIT]     = regs_q.enable;
                reg_rdata[EVT_HI:1]   = regs_q.ien;
            end
            OFS_CFG: begin
                reg_rdata[DATA_W-1 -: MAX_W] = regs_q.max_cyc;
                reg_rdata[MIN_W-1:0]         = regs_q.min_cyc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rng_obuf_chk.sv
module rng_obuf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  reg_addr,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        ready,
    input logic        enable,
    input logic [7:1]  ien,
    input logic [7:1]  sts,
    input logic        stuck_evt,
    input logic        irq
);
    AST_DATA_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < 8'h10 && !ready) |-> (reg_rdata == 32'h0)); // R2
    AST_READY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h10 && reg_wdata[0] && ready) |=> !ready); // R5
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(enable)); // R9
    AST_STUCK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_evt |=> sts[2]); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 7'h0) |-> !irq); // R10
endmodule

bind rng_obuf_top rng_obuf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ready(ready),
    .enable(regs_q.enable), .ien(regs_q.ien), .sts(sts),
    .stuck_evt(stuck_evt), .irq(irq)
);

// File: tb/tb_rng_obuf_top.sv
module tb_rng_obuf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rnd_valid = 1'b0;
    logic [31:0] rnd_data = '0;
    logic        fro_shutdown = 1'b0;
    logic [4:0]  health_fail = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] w [4];
    logic [31:0] rv;
    localparam logic [31:0] EN = 32'h400;

    always #10 clk = ~clk;

    rng_obuf_top dut (.*);

    function automatic logic [31:0] status_exp(input logic rdy, input logic [7:1] ev);
        return {24'h0, ev, rdy};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        rnd_valid = 1'b1; rnd_data = d;
        @(negedge clk);
        rnd_valid = 1'b0;
    endtask

    task automatic fresh_words();
        for (int i = 0; i < 4; i++) begin
            w[i] = $urandom;
            if (i > 0 && w[i] == w[i-1]) w[i] = w[i] ^ 32'h1;
        end
    endtask

    task automatic check_words(input string req);
        for (int i = 0; i < 4; i++) begin
            rd(8'(4 * i), rv);
            chk(req, rv, w[i]);
        end
    endtask

    initial begin
        cyc(200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // reset state
        rd(8'h10, rv); chk("R3 reset status", rv, 32'h0);
        rd(8'h14, rv); chk("R11 reset ctrl", rv, 32'h0);
        chk("R10 reset irq", {31'h0, irq}, 32'h0);

        // basic fill, min 0 max 0
        wr(8'h18, 32'h0);
        wr(8'h14, EN);
        fresh_words();
        for (int i = 0; i < 3; i++) push(w[i]);
        cyc(3);
        rd(8'h10, rv); chk("R3 three words not ready", rv, 32'h0);
        rd(8'h00, rv); chk("R2 read while not ready", rv, 32'h0);
        push(w[3]);
        cyc(1);
        rd(8'h10, rv); chk("R3 ready after four words", rv, status_exp(1'b1, 7'h0));
        check_words("R1 words in order");
        wr(8'h04, 32'hDEAD_BEEF);
        rd(8'h04, rv); chk("R2 data write ignored", rv, w[1]);
        push(32'h1234_5678);
        check_words("R5 no accept while ready");

        // acknowledge then minimum pacing
        wr(8'h18, 32'd30);
        wr(8'h10, 32'h1);
        rd(8'h10, rv); chk("R5 ack clears ready", rv, 32'h0);
        fresh_words();
        for (int i = 0; i < 4; i++) push(w[i]);
        cyc(10);
        rd(8'h10, rv); chk("R3 min cycles hold ready low", rv, 32'h0);
        cyc(25);
        rd(8'h10, rv); chk("R3 ready after min cycles", rv, 32'h1);
        check_words("R1 second set");

        // maximum forces completion
        wr(8'h18, {16'd12, 16'd0});
        wr(8'h10, 32'h1);
        w[0] = $urandom; w[1] = 0; w[2] = 0; w[3] = 0;
        push(w[0]);
        cyc(20);
        rd(8'h10, rv); chk("R4 forced ready", rv, 32'h1);
        check_words("R4 partial set zero filled");

        // disabled generator
        wr(8'h18, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h1);
        for (int i = 0; i < 4; i++) push($urandom);
        cyc(10);
        rd(8'h10, rv); chk("R9 disabled no ready", rv, 32'h0);
        wr(8'h14, EN);
        fresh_words();
        for (int i = 0; i < 4; i++) push(w[i]);
        cyc(2);
        rd(8'h10, rv); chk("R9 enabled ready", rv, 32'h1);
        check_words("R9 disabled words dropped");

        // stuck output
        wr(8'h10, 32'h1);
        rv = $urandom;
        push(rv); push(rv);
        cyc(1);
        rd(8'h10, rv); chk("R6 stuck bit set", rv, status_exp(1'b0, 7'h02));
        chk("R10 stuck masked", {31'h0, irq}, 32'h0);
        wr(8'h14, EN | 32'h4);
        chk("R10 stuck enabled irq", {31'h0, irq}, 32'h1);
        wr(8'h10, 32'h4);
        rd(8'h10, rv); chk("R8 stuck cleared", rv, 32'h0);
        chk("R10 irq drops", {31'h0, irq}, 32'h0);
        fresh_words();
        push(w[2]); push(w[3]);
        cyc(2);
        wr(8'h14, EN | 32'hFE);
        rd(8'h10, rv); chk("R10 ready only status", rv, 32'h1);
        chk("R10 ready never interrupts", {31'h0, irq}, 32'h0);

        // random events: k=0 shutdown bit1, k=1..5 health bit 2+k
        for (int n = 0; n < 12; n++) begin
            automatic int k = int'($urandom % 6);
            automatic int b = (k == 0) ? 1 : k + 2;
            automatic logic e = 1'($urandom);
            automatic logic [7:1] m = 7'(1 << (b - 1));
            wr(8'h14, EN | (e ? (32'h1 << b) : 32'h0));
            if (k == 0) fro_shutdown = 1'b1; else health_fail = 5'(1 << (k - 1));
            @(negedge clk);
            fro_shutdown = 1'b0; health_fail = '0;
            rd(8'h10, rv); chk("R7 event bit", rv, status_exp(1'b1, m));
            chk("R10 event irq", {31'h0, irq}, {31'h0, e});
            if (n == 0) begin
                reg_addr = 8'h10; reg_wdata = 32'(m) << 1; reg_wr = 1'b1;
                if (k == 0) fro_shutdown = 1'b1; else health_fail = 5'(1 << (k - 1));
                @(negedge clk);
                reg_wr = 1'b0; fro_shutdown = 1'b0; health_fail = '0;
                rd(8'h10, rv); chk("R8 set wins over clear", rv, status_exp(1'b1, m));
            end
            wr(8'h10, 32'(m) << 1);
            rd(8'h10, rv); chk("R8 event cleared", rv, 32'h1);
        end

        // readback masks
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, rv); chk("R11 ctrl mask", rv, 32'h0000_04FE);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, rv); chk("R11 cfg mask", rv, 32'hFFFF_00FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule